// File: doc/BRIEF.md
# Loadable One-Shot / Periodic Event Timer

This block is a memory-mapped down-counting event timer with a 56-bit interval. Software stages the low 32 bits of the interval in one register. It then writes a control word that carries the remaining 24 interval bits together with three command flags: load, run and repeat. That single control write completes the interval and, when the run flag is set, starts the countdown.

When the interval runs out, the timer latches a pending flag. In one-shot mode it then stops and drops its run flag. In repeat mode it reloads the stored interval and keeps going, so that it expires every N cycles.

The interrupt output is the pending flag gated by a mask bit. Separate write-one registers set the mask, clear the mask and clear the pending flag. The pending flag is captured whether or not the mask is open. An expiry that lands in the same cycle as a pending-clear wins over the clear. Writes use a simple 32-bit single-cycle bus. Reads are combinational.

Top module: `evt_timer`

## Requirements
- R1: After reset the interrupt output is low, and reads return zero for the low load word, for the control word and for the status word at 0x02c (bit 0 = mask, bit 1 = pending).
- R2: The interval is {control[23:0], low word} (low word at 0x000, control at 0x004). Both read back as written, and the upper 24 bits take part in the count: an interval of 2^32+3 does not expire within 20 cycles.
- R3: A control write with bit 30 (load) and bit 24 (run) set and bit 28 (repeat) clear raises pending exactly N clock edges after the write edge. Control bit 24 then reads 0.
- R4: With bit 28 set, the timer reloads the stored interval on each expiry and raises pending every N edges.
- R5: Writing zero to the control word stops the timer: no further expiry occurs, and control bits 24 and 28 read 0.
- R6: A control write with load set and run clear stores the interval without counting. A later write with run set and load clear starts the countdown from the stored count and expires N edges after that write.
- R7: Writing 1 to bit 0 at 0x02c opens the mask and writing 1 to bit 0 at 0x030 closes it. The interrupt output is high exactly when pending is set and the mask is open.
- R8: Pending is latched while the mask is closed. The output stays low until the mask opens, and the output rises on the edge that opens the mask.
- R9: Writing 1 to bit 0 at 0x034 clears pending. If an expiry occurs on the same edge, pending stays set.
- R10: The smallest legal interval, 2, expires two edges after the starting write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read strobe |
| irq | output | 1 | Interrupt, pending AND mask |

## Verification
The countdown is driven with intervals of 2, 4, 5 and 6 in one-shot, repeat and load-then-run sequences. A scoreboard compares the exact edge of each interrupt rise against the edge predicted from the starting write. These runs tell an off-by-one in the countdown apart from a missing reload or a one-shot that fails to stop. An interval whose only nonzero upper bit is bit 32 shows whether the high load field reaches the counter. A pending-clear timed onto an expiry edge, with a second clear timed off it, separates set-priority from clear-priority in the pending flag. Masked expiries followed by a mask-open show that capture and gating are independent.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  // Register byte offsets
  localparam int unsigned OFS_LOAD_LO  = 'h000;
  localparam int unsigned OFS_CTRL     = 'h004;
  localparam int unsigned OFS_MASK_SET = 'h02c;
  localparam int unsigned OFS_MASK_CLR = 'h030;
  localparam int unsigned OFS_PEND_CLR = 'h034;

  // Control word flag positions
  localparam int unsigned CTRL_RUN_BIT = 24;
  localparam int unsigned CTRL_REP_BIT = 28;
  localparam int unsigned CTRL_LD_BIT  = 30;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LO,
    SEL_CTRL,
    SEL_MSET,
    SEL_MCLR,
    SEL_PCLR
  } reg_sel_e;

  typedef struct packed {
    logic load;
    logic run;
    logic rep;
  } ctrl_flags_t;

endpackage

// File: rtl/evt_timer_bus.sv
module evt_timer_bus
  import evt_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HI_W   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              run_q,
  input  logic              rep_q,
  input  logic              mask_q,
  input  logic              pend_q,
  output logic [DATA_W-1:0] lo_q,
  output logic [HI_W-1:0]   hi_q,
  output logic [HI_W-1:0]   hi_wdata,
  output logic              ctrl_wr,
  output ctrl_flags_t       flags,
  output logic              mask_set,
  output logic              mask_clr,
  output logic              pend_clr,
  output logic [DATA_W-1:0] bus_rdata
);

  reg_sel_e          sel;
  logic              wr_stb;
  logic              lo_ce;
  logic              hi_ce;
  logic [DATA_W-1:0] lo_d;
  logic [HI_W-1:0]   hi_d;
  logic              unused_wdata_bits;

  // Address decode
  always_comb begin
    if (bus_addr == ADDR_W'(OFS_LOAD_LO))       sel = SEL_LO;
    else if (bus_addr == ADDR_W'(OFS_CTRL))     sel = SEL_CTRL;
    else if (bus_addr == ADDR_W'(OFS_MASK_SET)) sel = SEL_MSET;
    else if (bus_addr == ADDR_W'(OFS_MASK_CLR)) sel = SEL_MCLR;
    else if (bus_addr == ADDR_W'(OFS_PEND_CLR)) sel = SEL_PCLR;
    else                                         sel = SEL_NONE;
  end

  assign wr_stb   = bus_en & bus_wr;
  assign ctrl_wr  = wr_stb & (sel == SEL_CTRL);
  assign mask_set = wr_stb & (sel == SEL_MSET) & bus_wdata[0];
  assign mask_clr = wr_stb & (sel == SEL_MCLR) & bus_wdata[0];
  assign pend_clr = wr_stb & (sel == SEL_PCLR) & bus_wdata[0];

  assign hi_wdata   = bus_wdata[HI_W-1:0];
  assign flags.load = bus_wdata[CTRL_LD_BIT];
  assign flags.run  = bus_wdata[CTRL_RUN_BIT];
  assign flags.rep  = bus_wdata[CTRL_REP_BIT];

  assign unused_wdata_bits = ^{bus_wdata[DATA_W-1:CTRL_LD_BIT+1],
                               bus_wdata[CTRL_LD_BIT-1:CTRL_REP_BIT+1],
                               bus_wdata[CTRL_REP_BIT-1:CTRL_RUN_BIT+1]};

  // Next state of the staging registers
  always_comb begin
    lo_ce = wr_stb & (sel == SEL_LO);
    hi_ce = ctrl_wr;
    lo_d  = bus_wdata;
    hi_d  = hi_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_ce) lo_q <= lo_d;
      if (hi_ce) hi_q <= hi_d;
    end
  end

  // Combinational read path
  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_wr) begin
      unique case (sel)
        SEL_LO:   bus_rdata = lo_q;
        SEL_CTRL: begin
          bus_rdata[HI_W-1:0]    = hi_q;
          bus_rdata[CTRL_RUN_BIT] = run_q;
          bus_rdata[CTRL_REP_BIT] = rep_q;
        end
        SEL_MSET: begin
          bus_rdata[0] = mask_q;
          bus_rdata[1] = pend_q;
        end
        default:  bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/evt_timer_cnt.sv
module evt_timer_cnt
  import evt_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 56
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  ctrl_flags_t      flags,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic             run_q,
  output logic             rep_q,
  output logic             expire
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             run_d;
  logic             rep_d;
  logic             cnt_ce;
  logic             at_end;

  // A count of 1 (or 0 after an undersized load) ends the interval
  assign at_end = (count_q <= CNT_W'(1));
  // A control write in the same cycle takes precedence over expiry
  assign expire = run_q & at_end & ~ctrl_wr;
  assign cnt_ce = ctrl_wr | run_q;

  always_comb begin
    count_d = count_q;
    run_d   = run_q;
    rep_d   = rep_q;
    if (ctrl_wr) begin
      run_d = flags.run;
      rep_d = flags.rep;
      if (flags.load) count_d = load_val;
    end else if (expire) begin
      if (rep_q) count_d = reload_val;
      else       run_d   = 1'b0;
    end else if (run_q) begin
      count_d = count_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      run_q   <= 1'b0;
      rep_q   <= 1'b0;
    end else if (cnt_ce) begin
      count_q <= count_d;
      run_q   <= run_d;
      rep_q   <= rep_d;
    end
  end

endmodule

// File: rtl/evt_timer_irq.sv
module evt_timer_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic mask_set,
  input  logic mask_clr,
  input  logic pend_clr,
  input  logic expire,
  output logic mask_q,
  output logic pend_q,
  output logic irq
);

  logic mask_d;
  logic pend_d;
  logic irq_ce;

  always_comb begin
    mask_d = mask_q;
    if (mask_set)      mask_d = 1'b1;
    else if (mask_clr) mask_d = 1'b0;
    // Expiry outranks a clear on the same edge
    pend_d = pend_q;
    if (expire)        pend_d = 1'b1;
    else if (pend_clr) pend_d = 1'b0;
    irq_ce = mask_set | mask_clr | pend_clr | expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (irq_ce) begin
      mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end

  assign irq = pend_q & mask_q;

endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 56
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int unsigned HI_W = CNT_W - DATA_W;

  logic [1:0]        rst_pipe;
  logic              rst_ni;
  logic [DATA_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [HI_W-1:0]   hi_wdata;
  logic              ctrl_wr;
  ctrl_flags_t       flags;
  logic              mask_set;
  logic              mask_clr;
  logic              pend_clr;
  logic              run_q;
  logic              rep_q;
  logic              mask_q;
  logic              pend_q;
  logic              expire;
  logic [CNT_W-1:0]  load_val;
  logic [CNT_W-1:0]  reload_val;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  assign load_val   = {hi_wdata, lo_q};
  assign reload_val = {hi_q, lo_q};

  evt_timer_bus #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .HI_W   (HI_W)
  ) u_bus (
    .clk       (clk),
    .rst_n     (rst_ni),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .run_q     (run_q),
    .rep_q     (rep_q),
    .mask_q    (mask_q),
    .pend_q    (pend_q),
    .lo_q      (lo_q),
    .hi_q      (hi_q),
    .hi_wdata  (hi_wdata),
    .ctrl_wr   (ctrl_wr),
    .flags     (flags),
    .mask_set  (mask_set),
    .mask_clr  (mask_clr),
    .pend_clr  (pend_clr),
    .bus_rdata (bus_rdata)
  );

  evt_timer_cnt #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_ni),
    .ctrl_wr    (ctrl_wr),
    .flags      (flags),
    .load_val   (load_val),
    .reload_val (reload_val),
    .run_q      (run_q),
    .rep_q      (rep_q),
    .expire     (expire)
  );

  evt_timer_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_ni),
    .mask_set (mask_set),
    .mask_clr (mask_clr),
    .pend_clr (pend_clr),
    .expire   (expire),
    .mask_q   (mask_q),
    .pend_q   (pend_q),
    .irq      (irq)
  );

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
  import evt_timer_pkg::*;
(
  input logic        clk,
  input logic        rst_ni,
  input logic        ctrl_wr,
  input ctrl_flags_t flags,
  input logic        run_q,
  input logic        rep_q,
  input logic        expire,
  input logic        pend_q,
  input logic        pend_clr,
  input logic        mask_q,
  input logic        irq
);

  // R3: a one-shot expiry drops the run flag
  p_oneshot_stops_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (expire && !rep_q) |=> !run_q);

  // R4: a repeat expiry keeps the timer running
  p_repeat_keeps_running_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (expire && rep_q) |=> run_q);

  // R5: a control write without the run flag leaves the timer stopped
  p_stop_write_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_wr && !flags.run) |=> !run_q);

  // R5: a stopped timer raises no new pending flag
  p_stopped_quiet_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (!run_q && !ctrl_wr && !pend_q) |=> !pend_q);

  // R7: the output never rises with the mask closed
  p_irq_needs_mask_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |-> mask_q);

  // R8: pending holds until a clear
  p_pend_holds_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (pend_q && !pend_clr) |=> pend_q);

  // R9: an expiry sets pending even against a clear
  p_expiry_sets_pend_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    expire |=> pend_q);

endmodule

bind evt_timer evt_timer_chk u_chk (
  .clk      (clk),
  .rst_ni   (rst_ni),
  .ctrl_wr  (ctrl_wr),
  .flags    (flags),
  .run_q    (run_q),
  .rep_q    (rep_q),
  .expire   (expire),
  .pend_q   (pend_q),
  .pend_clr (pend_clr),
  .mask_q   (mask_q),
  .irq      (irq)
);

// File: tb/evt_timer_tb.sv
`timescale 1ns/1ps
module evt_timer_tb;

  localparam logic [7:0] A_LO   = 8'h00;
  localparam logic [7:0] A_CTRL = 8'h04;
  localparam logic [7:0] A_MSET = 8'h2c;
  localparam logic [7:0] A_MCLR = 8'h30;
  localparam logic [7:0] A_PCLR = 8'h34;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit finished = 0;

  typedef struct {
    int    at;
    string req;
  } exp_t;
  exp_t exp_q[$];

  evt_timer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(input bit ld, input bit run, input bit rep, input logic [23:0] hi);
    logic [31:0] w;
    w = {8'h00, hi};
    w[30] = ld;
    w[24] = run;
    w[28] = rep;
    return w;
  endfunction

  task automatic wr_now(input logic [7:0] a, input logic [31:0] d, output int t);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    t = cyc;
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output int t);
    @(negedge clk);
    wr_now(a, d, t);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic wait_irq();
    do @(negedge clk); while (!irq);
  endtask

  // Monitor: every rising edge of irq must match the next expected item
  bit irq_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (irq && !irq_prev) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected irq rise", cyc, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(cyc == e.at, e.req, cyc, e.at);
        end
      end
      irq_prev = irq;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung (R3 expiry wait) actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int t;
    int t0;
    logic [31:0] d;
    rst_n = 1'b0; bus_en = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(irq == 1'b0, "R1 irq after reset", irq, 0);
    rd(A_CTRL, d); check(d == 0, "R1 control after reset", d, 0);
    rd(A_MSET, d); check(d == 0, "R1 status after reset", d, 0);
    rd(A_LO, d);   check(d == 0, "R1 low word after reset", d, 0);

    // R3 one-shot, interval 5
    wr(A_MSET, 32'h1, t);
    rd(A_MSET, d); check(d == 32'h1, "R7 mask bit after set", d, 1);
    wr(A_LO, 32'd5, t);
    wr(A_CTRL, cw(1, 1, 0, 24'h0), t0);
    exp_q.push_back('{t0 + 5, "R3 one-shot expiry edge"});
    wait_irq();
    rd(A_CTRL, d); check(d[24] == 1'b0, "R3 run flag cleared", d[24], 0);
    wr(A_PCLR, 32'h1, t);
    @(negedge clk); check(irq == 1'b0, "R9 clear drops irq", irq, 0);

    // R10 minimum interval
    wr(A_LO, 32'd2, t);
    wr(A_CTRL, cw(1, 1, 0, 24'h0), t0);
    exp_q.push_back('{t0 + 2, "R10 interval 2 expiry edge"});
    wait_irq();
    wr(A_PCLR, 32'h1, t);

    // R4 repeat, interval 4, then R5 stop
    wr(A_LO, 32'd4, t);
    wr(A_CTRL, cw(1, 1, 1, 24'h0), t0);
    for (int i = 1; i <= 3; i++) exp_q.push_back('{t0 + 4 * i, "R4 periodic expiry edge"});
    for (int i = 0; i < 3; i++) begin
      wait_irq();
      wr(A_PCLR, 32'h1, t);
    end
    wr(A_CTRL, 32'h0, t);
    repeat (20) @(negedge clk);
    rd(A_MSET, d); check(d[1] == 1'b0, "R5 no expiry after stop", d[1], 0);
    rd(A_CTRL, d); check(d[28:24] == 5'b0, "R5 run and repeat read 0", d[28:24], 0);

    // R8 masked capture, then R7 open
    wr(A_MCLR, 32'h1, t);
    wr(A_LO, 32'd3, t);
    wr(A_CTRL, cw(1, 1, 0, 24'h0), t);
    repeat (8) @(negedge clk);
    check(irq == 1'b0, "R8 irq low while masked", irq, 0);
    rd(A_MSET, d); check(d[1:0] == 2'b10, "R8 pending latched, mask closed", d[1:0], 2);
    wr(A_MSET, 32'h1, t);
    exp_q.push_back('{t, "R7 irq rises on mask open"});
    @(negedge clk); check(irq == 1'b1, "R7 irq high with mask open", irq, 1);
    wr(A_PCLR, 32'h1, t);
    @(negedge clk); check(irq == 1'b0, "R9 irq low after clear", irq, 0);

    // R9 clear on an expiry edge (mask closed)
    wr(A_MCLR, 32'h1, t);
    wr(A_LO, 32'd3, t);
    wr(A_CTRL, cw(1, 1, 1, 24'h0), t0);
    @(negedge clk);
    while (cyc != t0 + 5) @(negedge clk);
    wr_now(A_PCLR, 32'h1, t);
    rd(A_MSET, d); check(d[1] == 1'b1, "R9 expiry beats same-edge clear", d[1], 1);
    wr(A_PCLR, 32'h1, t);
    rd(A_MSET, d); check(d[1] == 1'b0, "R9 clear off the expiry edge", d[1], 0);
    wr(A_CTRL, 32'h0, t);
    wr(A_PCLR, 32'h1, t);

    // R2 upper load bits take part
    wr(A_LO, 32'd3, t);
    wr(A_CTRL, cw(1, 1, 0, 24'h000001), t);
    repeat (20) @(negedge clk);
    rd(A_MSET, d); check(d[1] == 1'b0, "R2 high bits extend the interval", d[1], 0);
    rd(A_CTRL, d); check(d[24:0] == 25'h1000001, "R2 control readback", d[24:0], 25'h1000001);
    rd(A_LO, d);   check(d == 32'd3, "R2 low word readback", d, 3);
    wr(A_CTRL, 32'h0, t);

    // R6 load without run, then run without load
    wr(A_MSET, 32'h1, t);
    wr(A_LO, 32'd6, t);
    wr(A_CTRL, cw(1, 0, 0, 24'h0), t);
    repeat (10) @(negedge clk);
    check(irq == 1'b0, "R6 load alone does not count", irq, 0);
    rd(A_MSET, d); check(d[1:0] == 2'b01, "R6 no pending after load alone", d[1:0], 1);
    wr(A_CTRL, cw(0, 1, 0, 24'h0), t0);
    exp_q.push_back('{t0 + 6, "R6 run from stored count"});
    wait_irq();
    wr(A_PCLR, 32'h1, t);

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R3 all expected expiries seen", exp_q.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule